// File: doc/BRIEF.md
# Single-Descriptor Transmit DMA Engine

This block moves one outgoing frame from system memory to a MAC. Software places a four-word descriptor in memory, hands it to the engine by setting its ownership bit, and then writes any value to the poll register. If transmission is enabled, the engine reads the descriptor from its current ring position. The four words, in memory order, are the status word, the control word (length and flags), the buffer pointer and the next-descriptor pointer.

The engine streams the buffer to the MAC one byte at a time, using a valid/ready handshake. It then waits for the MAC to report completion, with underflow, late-collision and collision-count information. Finally it writes a status word back into the descriptor with the ownership bit cleared, which returns the descriptor to software.

A small register port holds four registers: bus mode (whose bit 0 is a self-clearing soft reset), poll, ring base and operation control. Memory is reached through a simple word-wide master that holds a request until it is acknowledged.

Top module: `txdesc_dma`

## Requirements
- R1: After `rst`, `mem_req` and `tx_valid` are low, and the ring base (offset 0x10) and operation control (offset 0x18) registers read 0.
- R2: A write of any value to offset 0x04 while bit 13 of offset 0x18 is set makes the engine read four words at the current descriptor address A: A, A+4, A+8, A+12 in that order. The current address is loaded from offset 0x10 whenever that register is written.
- R3: While bit 13 of offset 0x18 is clear, a poll write causes no memory access. The demand is kept, and the fetch begins once bit 13 is set.
- R4: If bit 31 of the fetched status word is 0, the engine makes no further memory access and sends no bytes. It returns to idle at the same descriptor address.
- R5: The engine sends exactly control[10:0] bytes. Each buffer word is sent most significant byte first, so buffer byte j goes out as byte j. `tx_last` is high only on the final byte, and a final partial word sends only the bytes that remain.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R7: After MAC completion, the engine writes one status word to address A with the following fields:
  - bit 31 is 0;
  - bit 1 is `mac_underflow`;
  - bit 9 is `mac_late_col`;
  - bits 6:3 are `mac_col_cnt`;
  - bit 15 is the OR of underflow and late collision;
  - all other bits are 0.
- R8: A completion that arrives in the same cycle as the final byte handshake is captured and written back exactly as a later completion would be.
- R9: After writeback, the next descriptor address depends on the control word. With end-of-ring (control bit 25) set, it is the ring base. Otherwise, with chained (bit 24) set, it is the fetched next-descriptor pointer. Otherwise it is A+16.
- R10: Writing 1 to bit 0 of offset 0x00 returns the engine to idle. It drops `tx_valid` and `mem_req`, performs no writeback, and clears the ring base and operation control registers.
- R11: A poll write that arrives while a frame is in progress is remembered. A new descriptor fetch starts after the writeback.
- R12: A memory request keeps `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`. Each frame costs 4 descriptor reads, ceil(length/4) buffer reads and 1 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data (status writeback) |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte stream valid |
| tx_data | output | 8 | Byte stream data |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| mac_done | input | 1 | MAC completion pulse |
| mac_underflow | input | 1 | MAC reports underflow |
| mac_late_col | input | 1 | MAC reports late collision |
| mac_col_cnt | input | 4 | MAC collision count |

## Verification
Two events can fall in the same clock cycle.

- **Completion on the final byte.** The MAC's completion can coincide with the handshake of the final byte. The bench provokes this by deriving `mac_done` combinationally from `tx_valid`, `tx_ready` and `tx_last`. It judges the outcome by the status word in memory, which must carry the reported late collision and count.
- **Poll during a busy frame.** A poll write can land while the engine is busy with a frame. The bench writes the poll after the first byte has gone out. It then expects exactly one extra status read at the ring base after the writeback, and no further traffic.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int REG_AW     = 5;
  localparam int WORD_W     = 32;
  localparam int BPW        = WORD_W / 8;
  localparam int BCW        = $clog2(BPW);
  localparam int DESC_BYTES = 4 * BPW;

  localparam logic [REG_AW-1:0] OFS_BUSMODE = 5'h00;
  localparam logic [REG_AW-1:0] OFS_POLL    = 5'h04;
  localparam logic [REG_AW-1:0] OFS_RING    = 5'h10;
  localparam logic [REG_AW-1:0] OFS_OPCTL   = 5'h18;

  localparam int BIT_SWR    = 0;
  localparam int BIT_START  = 13;
  localparam int BIT_OWN    = 31;
  localparam int BIT_ERRSUM = 15;
  localparam int BIT_UNDER  = 1;
  localparam int BIT_LATE   = 9;
  localparam int COL_LSB    = 3;
  localparam int COL_W      = 4;
  localparam int BIT_CHAIN  = 24;
  localparam int BIT_EOR    = 25;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_BUFRD, S_SEND, S_WAIT, S_WB
  } eng_state_t;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fetch_take,
  output logic              poll_pend,
  output logic              start_en,
  output logic [AW-1:0]     ring_base,
  output logic              ring_load,
  output logic              swr
);
  logic [31:0] busmode_q;
  logic [31:0] opctl_q;

  assign start_en = opctl_q[BIT_START];

  always_ff @(posedge clk) begin
    if (rst || swr) begin
      busmode_q <= '0;
      opctl_q   <= '0;
      ring_base <= '0;
      ring_load <= 1'b0;
      poll_pend <= 1'b0;
      reg_rdata <= '0;
      swr       <= 1'b0;
    end else begin
      ring_load <= 1'b0;
      swr       <= 1'b0;
      if (fetch_take) poll_pend <= 1'b0;
      if (reg_wen) begin
        case (reg_addr)
          OFS_BUSMODE: begin
            busmode_q <= reg_wdata & ~32'h1;
            swr       <= reg_wdata[BIT_SWR];
          end
          OFS_POLL:  poll_pend <= 1'b1;
          OFS_RING: begin
            ring_base <= reg_wdata[AW-1:0];
            ring_load <= 1'b1;
          end
          OFS_OPCTL: opctl_q <= reg_wdata;
          default: ;
        endcase
      end
      case (reg_addr)
        OFS_BUSMODE: reg_rdata <= busmode_q;
        OFS_RING:    reg_rdata <= 32'(ring_base);
        OFS_OPCTL:   reg_rdata <= opctl_q;
        default:     reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_pend,
  input  logic              start_en,
  input  logic [AW-1:0]     ring_base,
  input  logic              ring_load,
  output logic              fetch_take,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              mac_done,
  input  logic              mac_underflow,
  input  logic              mac_late_col,
  input  logic [COL_W-1:0]  mac_col_cnt
);
  eng_state_t         st_q;
  logic [AW-1:0]      cur_q, buf_q, nxt_q, baddr_q;
  logic [LEN_W-1:0]   len_q, rem_q;
  logic               eor_q, chain_q;
  logic [1:0]         widx_q;
  logic [WORD_W-1:0]  word_q;
  logic [BCW-1:0]     bcnt_q;
  logic               cpl_q, uf_q, late_q;
  logic [COL_W-1:0]   col_q;
  logic [AW-1:0]      next_ptr;
  logic               cpl_take;

  assign fetch_take = (st_q == S_IDLE) && poll_pend && start_en;
  assign cpl_take   = (st_q == S_SEND || st_q == S_WAIT) && mac_done && !cpl_q;
  assign next_ptr   = eor_q   ? ring_base :
                      chain_q ? nxt_q     : cur_q + AW'(DESC_BYTES);

  assign tx_valid = (st_q == S_SEND);
  assign tx_data  = word_q[WORD_W-1 -: 8];
  assign tx_last  = tx_valid && (rem_q == LEN_W'(1));

  always_comb begin
    mem_req   = (st_q == S_DESC) || (st_q == S_BUFRD) || (st_q == S_WB);
    mem_we    = (st_q == S_WB);
    mem_wdata = '0;
    mem_wdata[BIT_UNDER]           = uf_q;
    mem_wdata[BIT_LATE]            = late_q;
    mem_wdata[COL_LSB +: COL_W]    = col_q;
    mem_wdata[BIT_ERRSUM]          = uf_q | late_q;
    case (st_q)
      S_DESC:  mem_addr = cur_q + AW'({widx_q, 2'b00});
      S_BUFRD: mem_addr = baddr_q;
      S_WB:    mem_addr = cur_q;
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      cur_q   <= '0;
      buf_q   <= '0;
      nxt_q   <= '0;
      baddr_q <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      eor_q   <= 1'b0;
      chain_q <= 1'b0;
      widx_q  <= '0;
      word_q  <= '0;
      bcnt_q  <= '0;
      cpl_q   <= 1'b0;
      uf_q    <= 1'b0;
      late_q  <= 1'b0;
      col_q   <= '0;
    end else begin
      if (ring_load) cur_q <= ring_base;
      if (cpl_take) begin
        cpl_q  <= 1'b1;
        uf_q   <= mac_underflow;
        late_q <= mac_late_col;
        col_q  <= mac_col_cnt;
      end
      case (st_q)
        S_IDLE: if (fetch_take) begin
          st_q   <= S_DESC;
          widx_q <= '0;
        end
        S_DESC: if (mem_ack) begin
          widx_q <= widx_q + 2'd1;
          case (widx_q)
            2'd0: if (!mem_rdata[BIT_OWN]) st_q <= S_IDLE;
            2'd1: begin
              len_q   <= mem_rdata[LEN_W-1:0];
              eor_q   <= mem_rdata[BIT_EOR];
              chain_q <= mem_rdata[BIT_CHAIN];
            end
            2'd2: buf_q <= mem_rdata[AW-1:0];
            default: begin
              nxt_q   <= mem_rdata[AW-1:0];
              rem_q   <= len_q;
              baddr_q <= buf_q;
              st_q    <= (len_q == '0) ? S_WB : S_BUFRD;
            end
          endcase
        end
        S_BUFRD: if (mem_ack) begin
          word_q  <= mem_rdata;
          bcnt_q  <= '0;
          baddr_q <= baddr_q + AW'(BPW);
          st_q    <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          word_q <= word_q << 8;
          rem_q  <= rem_q - LEN_W'(1);
          bcnt_q <= bcnt_q + BCW'(1);
          if (rem_q == LEN_W'(1))           st_q <= S_WAIT;
          else if (bcnt_q == BCW'(BPW - 1)) st_q <= S_BUFRD;
        end
        S_WAIT: if (cpl_q || mac_done) st_q <= S_WB;
        S_WB: if (mem_ack) begin
          cur_q  <= next_ptr;
          cpl_q  <= 1'b0;
          uf_q   <= 1'b0;
          late_q <= 1'b0;
          col_q  <= '0;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              mac_done,
  input  logic              mac_underflow,
  input  logic              mac_late_col,
  input  logic [3:0]        mac_col_cnt
);
  logic          poll_pend, start_en, ring_load, swr_pulse, fetch_take, eng_rst;
  logic [AW-1:0] ring_base;

  assign eng_rst = rst | swr_pulse;

  txd_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_take(fetch_take),
    .poll_pend(poll_pend), .start_en(start_en), .ring_base(ring_base),
    .ring_load(ring_load), .swr(swr_pulse)
  );

  txd_engine #(.AW(AW), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(eng_rst), .poll_pend(poll_pend), .start_en(start_en),
    .ring_base(ring_base), .ring_load(ring_load), .fetch_take(fetch_take),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .mac_done(mac_done), .mac_underflow(mac_underflow),
    .mac_late_col(mac_late_col), .mac_col_cnt(mac_col_cnt)
  );
endmodule

// File: rtl/txd_chk.sv
module txd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          swr,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data
);
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst || swr)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst || swr)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R7
  own_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  // R7
  errsum_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && (mem_wdata[1] || mem_wdata[9])) |-> mem_wdata[15]);

  // R10
  swr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(swr) |-> (!mem_req && !tx_valid));
endmodule

bind txdesc_dma txd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .swr(swr_pulse), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/txdesc_dma_bench.sv
module txdesc_dma_bench;
  import txd_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              reg_wen = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req, mem_we;
  logic [31:0]       mem_addr, mem_wdata;
  logic              mem_ack = 1'b0;
  logic [31:0]       mem_rdata = '0;
  logic              tx_valid, tx_last, tx_ready;
  logic [7:0]        tx_data;
  logic              mac_done, mac_uf = 1'b0, mac_late = 1'b0;
  logic [3:0]        mac_col = '0;

  int   errors = 0, checks = 0;
  int   rdy_mode = 0;
  logic same_mode = 1'b0;
  logic ready_q = 1'b1;
  logic hs1 = 1'b0, done_late = 1'b0;

  logic [31:0] mem [0:63];
  logic [31:0] acc_addr [0:31];
  logic        acc_we [0:31];
  int          acc_n = 0, wb_n = 0;
  logic [7:0]  byte_log [0:31];
  logic        last_log [0:31];
  int          byte_n = 0, hold_viol = 0;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;

  assign tx_ready = ready_q;
  assign mac_done = same_mode ? (tx_valid && tx_ready && tx_last) : done_late;

  txdesc_dma u_txdesc_dma (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .mac_done(mac_done), .mac_underflow(mac_uf), .mac_late_col(mac_late),
    .mac_col_cnt(mac_col)
  );

  always @(posedge clk)
    ready_q <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ~ready_q : 1'b0;

  // memory model, MAC completion model and stream monitor
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wb_n <= wb_n + 1;
      end
      if (acc_n < 32) begin
        acc_addr[acc_n] <= mem_addr;
        acc_we[acc_n]   <= mem_we;
      end
      acc_n <= acc_n + 1;
    end else begin
      mem_ack <= 1'b0;
    end
    if (tx_valid && tx_ready) begin
      if (byte_n < 32) begin
        byte_log[byte_n] <= tx_data;
        last_log[byte_n] <= tx_last;
      end
      byte_n <= byte_n + 1;
    end
    if (prev_stall && !(tx_valid && tx_data == prev_data)) hold_viol <= hold_viol + 1;
    prev_stall <= tx_valid && !tx_ready;
    prev_data  <= tx_data;
    hs1        <= tx_valid && tx_ready && tx_last && !same_mode;
    done_late  <= hs1;
  end

  function automatic logic [7:0] bufbyte(int j);
    return 8'(8'h10 + j);
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [REG_AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_logs();
    @(negedge clk);
    acc_n = 0; wb_n = 0; byte_n = 0; hold_viol = 0;
  endtask

  task automatic setup_desc(int ptr, int len, logic [31:0] flags, logic [31:0] nxt);
    mem[ptr >> 2]       = 32'h8000_0000;
    mem[(ptr >> 2) + 1] = flags | 32'(len);
    mem[(ptr >> 2) + 2] = 32'h80;
    mem[(ptr >> 2) + 3] = nxt;
  endtask

  task automatic wait_wb(string tag);
    int t = 0;
    while (wb_n == 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check_eq({tag, " writeback seen"}, 32'(wb_n), 32'd1);
    repeat (6) @(negedge clk);
  endtask

  task automatic frame_check(int len, int dptr, logic [31:0] exp_st);
    int bad = 0;
    int nacc = 4 + (len + 3) / 4 + 1;
    check_eq("R5 byte count", 32'(byte_n), 32'(len));
    for (int j = 0; j < len && j < 32; j++) begin
      if (byte_log[j] !== bufbyte(j)) bad++;
      if (last_log[j] !== (j == len - 1)) bad++;
    end
    check_eq("R5 byte order/last", 32'(bad), 32'd0);
    check_eq("R12 access count", 32'(acc_n), 32'(nacc));
    bad = 0;
    for (int i = 0; i < 4; i++)
      if (acc_addr[i] !== 32'(dptr + 4 * i) || acc_we[i] !== 1'b0) bad++;
    check_eq("R2 descriptor read order", 32'(bad), 32'd0);
    check_eq("R7 writeback address", acc_addr[nacc - 1], 32'(dptr));
    check_eq("R7 status word", mem[dptr >> 2], exp_st);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check_eq("R1 mem_req", 32'(mem_req), 32'd0);
    check_eq("R1 tx_valid", 32'(tx_valid), 32'd0);
    reg_read(OFS_RING, d);  check_eq("R1 ring base", d, 32'd0);
    reg_read(OFS_OPCTL, d); check_eq("R1 opctl", d, 32'd0);
  endtask

  task automatic t_gate();
    reg_write(OFS_RING, 32'h40);
    setup_desc(32'h40, 6, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h1234);
    repeat (20) @(negedge clk);
    check_eq("R3 no access while stopped", 32'(acc_n), 32'd0);
    reg_write(OFS_OPCTL, 32'h2000);
    wait_wb("R3");
    frame_check(6, 32'h40, 32'h0);
  endtask

  task automatic t_errors();
    rdy_mode = 1; mac_uf = 1'b1; mac_col = 4'd5;
    setup_desc(32'h40, 9, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    wait_wb("R7");
    frame_check(9, 32'h40, 32'h0000_802A);
    check_eq("R6 hold under stall", 32'(hold_viol), 32'd0);
    rdy_mode = 0; mac_uf = 1'b0; mac_col = 4'd0;
  endtask

  task automatic t_same();
    same_mode = 1'b1; mac_late = 1'b1; mac_col = 4'd3;
    setup_desc(32'h40, 4, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h5);
    wait_wb("R8");
    frame_check(4, 32'h40, 32'h0000_8218);
    check_eq("R8 status with same-cycle completion", mem[16], 32'h0000_8218);
    same_mode = 1'b0; mac_late = 1'b0; mac_col = 4'd0;
  endtask

  task automatic t_chain();
    setup_desc(32'h40, 2, 32'h0100_0000, 32'h60);
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    wait_wb("R9");
    frame_check(2, 32'h40, 32'h0);
    setup_desc(32'h60, 3, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    wait_wb("R9");
    check_eq("R9 chained next address", acc_addr[0], 32'h60);
    frame_check(3, 32'h60, 32'h0);
    setup_desc(32'h40, 1, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    wait_wb("R9");
    check_eq("R9 end-of-ring wraps to base", acc_addr[0], 32'h40);
  endtask

  task automatic t_own();
    setup_desc(32'h40, 4, 32'h0200_0000, 32'h0);
    mem[16] = 32'h0;
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    repeat (30) @(negedge clk);
    check_eq("R4 single access", 32'(acc_n), 32'd1);
    check_eq("R4 access is read", 32'(acc_we[0]), 32'd0);
    check_eq("R4 no bytes", 32'(byte_n), 32'd0);
  endtask

  task automatic t_busy_poll();
    int t = 0;
    rdy_mode = 1;
    setup_desc(32'h40, 8, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    while (byte_n == 0 && t < 2000) begin @(negedge clk); t++; end
    reg_write(OFS_POLL, 32'h0);
    wait_wb("R11");
    repeat (30) @(negedge clk);
    check_eq("R11 extra fetch count", 32'(acc_n), 32'd8);
    check_eq("R11 extra fetch address", acc_addr[7], 32'h40);
    check_eq("R11 extra fetch is read", 32'(acc_we[7]), 32'd0);
    rdy_mode = 0;
  endtask

  task automatic t_swr();
    logic [31:0] d;
    int t = 0;
    rdy_mode = 2;
    setup_desc(32'h40, 5, 32'h0200_0000, 32'h0);
    clear_logs();
    reg_write(OFS_POLL, 32'h0);
    while (!tx_valid && t < 2000) begin @(negedge clk); t++; end
    reg_write(OFS_BUSMODE, 32'h1);
    repeat (3) @(negedge clk);
    check_eq("R10 tx_valid dropped", 32'(tx_valid), 32'd0);
    check_eq("R10 mem_req dropped", 32'(mem_req), 32'd0);
    reg_read(OFS_RING, d);  check_eq("R10 ring base cleared", d, 32'd0);
    reg_read(OFS_OPCTL, d); check_eq("R10 opctl cleared", d, 32'd0);
    check_eq("R10 no writeback", mem[16], 32'h8000_0000);
    rdy_mode = 0;
    clear_logs();
    reg_write(OFS_RING, 32'h40);
    reg_write(OFS_OPCTL, 32'h2000);
    reg_write(OFS_POLL, 32'h0);
    wait_wb("R10");
    frame_check(5, 32'h40, 32'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int k = 0; k < 16; k++)
      mem[32 + k] = {bufbyte(4*k), bufbyte(4*k+1), bufbyte(4*k+2), bufbyte(4*k+3)};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_errors();
    t_same();
    t_chain();
    t_own();
    t_busy_poll();
    t_swr();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule